// File: doc/BRIEF.md
# Event-Driven I2C Target Byte Engine

This block is the target (slave) side of a two-wire bus. It works one byte at a time and leaves every decision to a host. When a bus master starts a transfer, the engine shifts in the address byte. It compares the 7-bit address with its own address through a don't-care mask, and it can also answer the general call address. After that it receives or sends 8-bit data bytes. Each byte is followed by an acknowledge bit.

Every bus event raises a sticky event flag and loads an 8-bit event code. While the flag is up, the engine holds SCL low. This makes the master wait until the host has read the code, handled `rx_byte`, loaded `tx_byte` or changed `ack_enable`, and pulsed `evt_clear`. The engine never makes SCL edges. It only pulls SDA low, and it pulls SCL low to stretch the clock.

The bus lines are open-drain. `scl_in`/`sda_in` are the wired bus levels, and the two `*_drive_low` outputs switch the pull-down transistors. Both inputs pass through a synchronizer before any edge, START or STOP is detected.

Top module: `i2c_evt_slave`

## Requirements
- R1: Each transfer unit is 9 SCL clocks: 8 bits MSB first, then one acknowledge bit (SDA low = ACK).
  - After a START, bits [7:1] of the first byte are the address and bit 0 is the direction (1 = read).
  - An own-address match compares only the address bits whose `addr_mask` bit is 0. Address 0 never counts as an own match.
  - A match is ACKed on the ninth clock. An event is then raised with code 0x10 (write) or 0x18 (read), and `rx_byte` shows the address byte.
- R2: Address 0 with direction write is ACKed only while `gc_enable` is 1. It then raises code 0x20. With `gc_enable` at 0 it is NACKed and no event is raised.
- R3: A non-matching address, or any address while `ack_enable` is 0, is NACKed. No event is raised and SDA is never driven until the next START.
- R4: Every received data byte is ACKed if `ack_enable` is 1 and NACKed otherwise. The byte appears on `rx_byte`, and the event code is 0x30 (ACKed) or 0x38 (NACKed). After a NACKed byte the engine is no longer addressed.
- R5: In read mode, the byte is loaded from `tx_byte` when the host clears the event, and it is sent MSB first.
  - A master ACK after the byte gives code 0x40.
  - A master NACK gives code 0x48. After that NACK the engine leaves SDA released until the next START.
- R6: The event flag stays set until `evt_clear` is pulsed, and SCL is pulled low for exactly as long as the flag is set.
- R7: `evt_code` reads 0xF0 whenever no event is pending.
- R8: A STOP or repeated START while addressed, and not inside a byte, raises code 0x50. After a repeated START the engine takes the next byte as a fresh address.
- R9: A START or STOP while addressed, after two or more clocks of the current unit, raises the bus-error code 0xE0 and leaves the engine unaddressed.
- R10: The engine begins pulling SDA low only while SCL is low.
- R11: After reset:
  - no event is pending and `evt_code` is 0xF0;
  - neither line is driven;
  - `rx_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Wired SCL bus level |
| sda_in | input | 1 | Wired SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low |
| own_addr | input | 7 | Own 7-bit address |
| addr_mask | input | 7 | 1 = address bit ignored in comparison |
| gc_enable | input | 1 | Answer the general call address |
| ack_enable | input | 1 | ACK own address and received bytes |
| tx_byte | input | 8 | Next byte to send, taken at event clear |
| rx_byte | output | 8 | Last received address or data byte |
| evt_pending | output | 1 | Sticky event flag |
| evt_clear | input | 1 | One-cycle pulse that clears the event |
| evt_code | output | 8 | Code of the pending event, 0xF0 if none |

## Verification
The bus-error path is the hardest case to reach from the pins. It needs a START or STOP that arrives in the middle of a byte while the engine is addressed. An ordinary master never produces that. The bench master therefore addresses the engine, clocks three data bits, and then makes an SDA rising edge while SCL is high.

The repeated-START case is also hard to reach, because the engine must report it and then stretch the clock before the new address arrives. The bench drives it right after an ACKed data byte and then continues into a read.

// File: rtl/i2c_evt_pkg.sv
// Shared definitions for the I2C target byte engine.
// Assumes 8-bit event codes; the code values are fixed and visible to the host.
package i2c_evt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,   // not addressed, waiting for a START
        ST_ADDR,   // shifting in the address byte
        ST_RX,     // addressed, master writes
        ST_TX      // addressed, master reads
    } eng_state_t;

    localparam logic [7:0] CODE_NONE    = 8'hF0;
    localparam logic [7:0] CODE_ADDR_WR = 8'h10;
    localparam logic [7:0] CODE_ADDR_RD = 8'h18;
    localparam logic [7:0] CODE_GCALL   = 8'h20;
    localparam logic [7:0] CODE_RX_ACK  = 8'h30;
    localparam logic [7:0] CODE_RX_NACK = 8'h38;
    localparam logic [7:0] CODE_TX_ACK  = 8'h40;
    localparam logic [7:0] CODE_TX_NACK = 8'h48;
    localparam logic [7:0] CODE_STOP_RS = 8'h50;
    localparam logic [7:0] CODE_BUS_ERR = 8'hE0;

endpackage

// File: rtl/i2c_evt_line_watch.sv
// Synchronizes the SCL/SDA bus levels and detects SCL edges and START/STOP.
// Assumes clk is fast enough that each bus level is stable for several cycles.
module i2c_evt_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // first sampling stage of the raw bus levels
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sync[g] <= 1'b1;
                    sda_sync[g] <= 1'b1;
                end else begin
                    scl_sync[g] <= scl_in;
                    sda_sync[g] <= sda_in;
                end
            end
        end else begin : g_next
            // further stages against metastability
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sync[g] <= 1'b1;
                    sda_sync[g] <= 1'b1;
                end else begin
                    scl_sync[g] <= scl_sync[g-1];
                    sda_sync[g] <= sda_sync[g-1];
                end
            end
        end
    end

    assign scl_lvl = scl_sync[SYNC_STAGES-1];
    assign sda_lvl = sda_sync[SYNC_STAGES-1];

    // one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_evt_addr_cmp.sv
// Address decoder: masked own-address compare and general call detect.
// Assumes addr_byte holds the address in its upper bits and direction in bit 0.
module i2c_evt_addr_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   addr_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              gc_enable,
    output logic              own_hit,
    output logic              gc_hit,
    output logic              is_read
);
    logic [ADDR_W-1:0] addr;

    // split the byte and compare under the don't-care mask
    always_comb begin
        addr    = addr_byte[ADDR_W:1];
        is_read = addr_byte[0];
        own_hit = (addr != '0) && (((addr ^ own_addr) & ~addr_mask) == '0);
        gc_hit  = gc_enable && (addr == '0) && !addr_byte[0];
    end

endmodule

// File: rtl/i2c_evt_shreg.sv
// Byte shift register: parallel load, shift left with serial input.
// Assumes load and shift are never requested in the same cycle.
module i2c_evt_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    // hold, load or shift the byte
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load)     q <= load_val;
        else if (shift_en) q <= {q[W-2:0], shift_in};
    end

endmodule

// File: rtl/i2c_evt_slave.sv
// I2C target byte engine with a sticky event flag and clock stretching.
// Each bus event sets the flag, loads a code and holds SCL low until the host
// pulses evt_clear. Assumes an address byte of ADDR_W+1 == DATA_W bits.
module i2c_evt_slave
    import i2c_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              gc_enable,
    input  logic              ack_enable,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              evt_pending,
    input  logic              evt_clear,
    output logic [7:0]        evt_code
);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_ERR  = CNT_W'(2);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic own_hit, gc_hit, is_read;

    eng_state_t        st;
    logic              flag_q;
    logic [7:0]        code_q;
    logic              sda_q;
    logic [CNT_W-1:0]  cnt;
    logic              we_ack;
    logic              m_ack;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] sh_q;
    logic              sh_load, sh_shift, sh_in;
    logic              selected, mid_unit;

    i2c_evt_line_watch #(.SYNC_STAGES(SYNC_STAGES)) watch_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_evt_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
        .addr_byte(sh_q[ADDR_W:0]), .own_addr(own_addr), .addr_mask(addr_mask),
        .gc_enable(gc_enable), .own_hit(own_hit), .gc_hit(gc_hit), .is_read(is_read)
    );

    i2c_evt_shreg #(.W(DATA_W)) shreg_i (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(tx_byte),
        .shift_en(sh_shift), .shift_in(sh_in), .q(sh_q)
    );

    assign selected = (st == ST_RX) || (st == ST_TX);
    assign mid_unit = cnt >= CNT_ERR;

    // shifter control: sample on SCL rise when receiving, advance on fall when sending
    always_comb begin
        sh_load  = flag_q && evt_clear && (st == ST_TX);
        sh_in    = (st == ST_TX) ? 1'b0 : sda_lvl;
        sh_shift = 1'b0;
        if (!flag_q && !start_det && !stop_det) begin
            if ((st == ST_ADDR || st == ST_RX) && scl_rise && cnt < CNT_ACK)
                sh_shift = 1'b1;
            if (st == ST_TX && scl_fall && cnt != '0 && cnt < CNT_ACK)
                sh_shift = 1'b1;
        end
    end

    // main sequencer: bus conditions, bit counting, acknowledge and event raising
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            flag_q <= 1'b0;
            code_q <= CODE_NONE;
            sda_q  <= 1'b0;
            cnt    <= '0;
            we_ack <= 1'b0;
            m_ack  <= 1'b0;
            rx_q   <= '0;
        end else if (flag_q) begin
            if (evt_clear) begin
                flag_q <= 1'b0;
                if (st == ST_TX) sda_q <= ~tx_byte[DATA_W-1];
            end
        end else if (start_det) begin
            sda_q <= 1'b0;
            cnt   <= '0;
            if (selected) begin
                flag_q <= 1'b1;
                code_q <= mid_unit ? CODE_BUS_ERR : CODE_STOP_RS;
                st     <= mid_unit ? ST_IDLE : ST_ADDR;
            end else begin
                st <= ST_ADDR;
            end
        end else if (stop_det) begin
            sda_q <= 1'b0;
            cnt   <= '0;
            st    <= ST_IDLE;
            if (selected) begin
                flag_q <= 1'b1;
                code_q <= mid_unit ? CODE_BUS_ERR : CODE_STOP_RS;
            end
        end else if (st != ST_IDLE) begin
            if (scl_rise) begin
                cnt <= cnt + 1'b1;
                if (st == ST_TX && cnt == CNT_ACK) m_ack <= ~sda_lvl;
            end
            if (scl_fall) begin
                if (cnt == CNT_ACK) begin
                    case (st)
                        ST_ADDR: begin
                            if ((own_hit || gc_hit) && ack_enable) begin
                                sda_q <= 1'b1;
                            end else begin
                                st  <= ST_IDLE;
                                cnt <= '0;
                            end
                        end
                        ST_RX: begin
                            sda_q  <= ack_enable;
                            we_ack <= ack_enable;
                        end
                        default: sda_q <= 1'b0;
                    endcase
                end else if (cnt == CNT_LAST) begin
                    sda_q  <= 1'b0;
                    cnt    <= '0;
                    flag_q <= 1'b1;
                    case (st)
                        ST_ADDR: begin
                            rx_q   <= sh_q;
                            code_q <= gc_hit ? CODE_GCALL :
                                      (is_read ? CODE_ADDR_RD : CODE_ADDR_WR);
                            st     <= (is_read && !gc_hit) ? ST_TX : ST_RX;
                        end
                        ST_RX: begin
                            rx_q   <= sh_q;
                            code_q <= we_ack ? CODE_RX_ACK : CODE_RX_NACK;
                            if (!we_ack) st <= ST_IDLE;
                        end
                        default: begin
                            code_q <= m_ack ? CODE_TX_ACK : CODE_TX_NACK;
                            if (!m_ack) st <= ST_IDLE;
                        end
                    endcase
                end else if (st == ST_TX && cnt != '0) begin
                    sda_q <= ~sh_q[DATA_W-2];
                end
            end
        end
    end

    assign scl_drive_low = flag_q;
    assign sda_drive_low = sda_q;
    assign evt_pending   = flag_q;
    assign evt_code      = flag_q ? code_q : CODE_NONE;
    assign rx_byte       = rx_q;

    // R6: a raised event stays raised until the host clears it
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !evt_clear) |=> flag_q);

    // R3: an unaddressed engine never pulls SDA
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_q);

    // R10: SDA drive changes only while SCL is low, apart from releases at START/STOP
    assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_q) |-> (!$past(scl_lvl) || $past(start_det || stop_det)));

    // R1: the bit counter never passes the nine clocks of one unit
    assert_unit_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

endmodule

// File: tb/i2c_evt_slave_tb_top.sv
// Bench: behavioural bus master and host model with a per-clock reference check.
module i2c_evt_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       dut_scl, dut_sda;
    logic [6:0] own_addr = 7'h52;
    logic [6:0] addr_mask = 7'h00;
    logic       gc_enable = 1'b0;
    logic       ack_enable = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       evt_pending;
    logic       evt_clear = 1'b0;
    logic [7:0] evt_code;
    wire        scl_bus = !(m_scl_low || dut_scl);
    wire        sda_bus = !(m_sda_low || dut_sda);

    int   vectors = 0;
    int   fails = 0;
    logic chk_on = 1'b0;
    logic quiet = 1'b0;
    logic prev_sda = 1'b0;
    logic prev_scl = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_evt_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(dut_scl), .sda_drive_low(dut_sda),
        .own_addr(own_addr), .addr_mask(addr_mask), .gc_enable(gc_enable),
        .ack_enable(ack_enable), .tx_byte(tx_byte), .rx_byte(rx_byte),
        .evt_pending(evt_pending), .evt_clear(evt_clear), .evt_code(evt_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference expectation for an address byte, from the requirement text
    function automatic int exp_addr(input logic [7:0] b);
        logic [6:0] a;
        a = b[7:1];
        if (!ack_enable) return -1;
        if (a == 7'h00) return (!b[0] && gc_enable) ? 'h20 : -1;
        if (((a ^ own_addr) & ~addr_mask) == 7'h00) return b[0] ? 'h18 : 'h10;
        return -1;
    endfunction

    // per-clock comparison against the behavioural rules
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (chk_on) begin
            chk("R6 scl stretch equals flag", {31'b0, dut_scl}, {31'b0, evt_pending});
            if (!evt_pending) chk("R7 idle code", {24'b0, evt_code}, 32'hF0);
            if (quiet) chk("R3 quiet engine", {30'b0, dut_sda, evt_pending}, 32'h0);
            if (dut_sda && !prev_sda) chk("R10 drive starts with SCL low", {31'b0, prev_scl}, 32'h0);
            prev_sda = dut_sda;
            prev_scl = scl_bus;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        m_sda_low = !b;
        wait_n(HALF);
        scl_up();
        wait_n(HALF/2);
        r = sda_bus;
        wait_n(HALF/2);
        m_scl_low = 1'b1;
        wait_n(HALF);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0;
        wait_n(HALF);
        scl_up();
        wait_n(HALF);
        m_sda_low = 1'b1;
        wait_n(HALF);
        m_scl_low = 1'b1;
        wait_n(HALF);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1;
        wait_n(HALF);
        scl_up();
        wait_n(HALF);
        m_sda_low = 1'b0;
        wait_n(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ackbit);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, ackbit);
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic mack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            v[i] = r;
        end
        bit_io(mack, r);
    endtask

    task automatic host_clear();
        evt_clear = 1'b1;
        wait_n(1);
        evt_clear = 1'b0;
        wait_n(2);
    endtask

    task automatic expect_evt(input string req, input logic [7:0] code);
        chk({req, " flag"}, {31'b0, evt_pending}, 32'h1);
        chk({req, " code"}, {24'b0, evt_code}, {24'b0, code});
    endtask

    // address a write, checking the response against the model
    task automatic addr_phase(input string req, input logic [7:0] b);
        logic ack;
        int   e;
        e = exp_addr(b);
        wr_byte(b, ack);
        chk({req, " ack bit"}, {31'b0, ack}, (e < 0) ? 32'h1 : 32'h0);
        if (e < 0) chk({req, " no event"}, {31'b0, evt_pending}, 32'h0);
        else begin
            expect_evt(req, e[7:0]);
            chk({req, " address byte"}, {24'b0, rx_byte}, {24'b0, b});
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        wait_n(5);
        // R11: reset state
        chk("R11 flag", {31'b0, evt_pending}, 32'h0);
        chk("R11 code", {24'b0, evt_code}, 32'hF0);
        chk("R11 drives", {30'b0, dut_scl, dut_sda}, 32'h0);
        chk("R11 rx_byte", {24'b0, rx_byte}, 32'h0);
        rst_n = 1'b1;
        wait_n(4);
        chk_on = 1'b1;

        // R1 R4: addressed write, two ACKed bytes, then a NACKed byte
        m_start();
        addr_phase("R1 own write", 8'hA4);
        host_clear();
        wr_byte(8'h3C, ack);
        chk("R4 ack", {31'b0, ack}, 32'h0);
        expect_evt("R4 rx", 8'h30);
        chk("R4 data", {24'b0, rx_byte}, 32'h3C);
        host_clear();
        wr_byte(8'hC5, ack);
        expect_evt("R4 rx2", 8'h30);
        chk("R4 data2", {24'b0, rx_byte}, 32'hC5);
        ack_enable = 1'b0;
        host_clear();
        wr_byte(8'h11, ack);
        chk("R4 nack bit", {31'b0, ack}, 32'h1);
        expect_evt("R4 rx nack", 8'h38);
        chk("R4 data3", {24'b0, rx_byte}, 32'h11);
        ack_enable = 1'b1;
        host_clear();
        m_stop();
        chk("R4 no stop event after nack", {31'b0, evt_pending}, 32'h0);

        // R8: STOP while addressed
        m_start();
        addr_phase("R8 addr", 8'hA4);
        host_clear();
        wr_byte(8'h77, ack);
        expect_evt("R8 rx", 8'h30);
        host_clear();
        m_stop();
        expect_evt("R8 stop", 8'h50);
        host_clear();

        // R3: address mismatch stays silent
        quiet = 1'b1;
        m_start();
        addr_phase("R3 mismatch", 8'hA6);
        wr_byte(8'h00, ack);
        m_stop();
        quiet = 1'b0;
        wait_n(4);

        // R1: mask lets the low address bit be ignored
        addr_mask = 7'h01;
        m_start();
        addr_phase("R1 masked", 8'hA6);
        host_clear();
        m_stop();
        expect_evt("R1 masked stop", 8'h50);
        host_clear();
        addr_mask = 7'h00;

        // R2: general call off, then on
        quiet = 1'b1;
        m_start();
        addr_phase("R2 gc off", 8'h00);
        m_stop();
        quiet = 1'b0;
        gc_enable = 1'b1;
        m_start();
        addr_phase("R2 gc on", 8'h00);
        host_clear();
        wr_byte(8'h5A, ack);
        expect_evt("R2 gc data", 8'h30);
        host_clear();
        m_stop();
        expect_evt("R2 gc stop", 8'h50);
        host_clear();
        gc_enable = 1'b0;

        // R5: read two bytes, ACK then NACK, then the engine stays released
        m_start();
        addr_phase("R5 read addr", 8'hA5);
        tx_byte = 8'h96;
        host_clear();
        rd_byte(v, 1'b0);
        chk("R5 data1", {24'b0, v}, 32'h96);
        expect_evt("R5 tx ack", 8'h40);
        tx_byte = 8'h5B;
        host_clear();
        rd_byte(v, 1'b1);
        chk("R5 data2", {24'b0, v}, 32'h5B);
        expect_evt("R5 tx nack", 8'h48);
        tx_byte = 8'h00;
        host_clear();
        quiet = 1'b1;
        rd_byte(v, 1'b1);
        chk("R5 released after nack", {24'b0, v}, 32'hFF);
        m_stop();
        quiet = 1'b0;

        // R8: repeated START while addressed, then a read
        m_start();
        addr_phase("R8 rs addr", 8'hA4);
        host_clear();
        wr_byte(8'h21, ack);
        expect_evt("R8 rs rx", 8'h30);
        host_clear();
        m_start();
        expect_evt("R8 repeated start", 8'h50);
        host_clear();
        addr_phase("R8 readdress", 8'hA5);
        tx_byte = 8'h3E;
        host_clear();
        rd_byte(v, 1'b1);
        chk("R8 read after rs", {24'b0, v}, 32'h3E);
        expect_evt("R8 tx nack", 8'h48);
        host_clear();
        m_stop();
        chk("R8 idle after stop", {31'b0, evt_pending}, 32'h0);

        // R9: STOP in the middle of a byte
        m_start();
        addr_phase("R9 addr", 8'hA4);
        host_clear();
        bit_io(1'b1, ack);
        bit_io(1'b0, ack);
        bit_io(1'b1, ack);
        m_stop();
        expect_evt("R9 bus error", 8'hE0);
        host_clear();
        quiet = 1'b1;
        wait_n(20);
        quiet = 1'b0;

        // R3: own address with ack disabled
        ack_enable = 1'b0;
        quiet = 1'b1;
        m_start();
        addr_phase("R3 ack off", 8'hA4);
        m_stop();
        quiet = 1'b0;
        ack_enable = 1'b1;
        wait_n(10);

        finish_run();
    end

endmodule